// File: doc/BRIEF.md
# Microprogram Sequencer

This block is the sequencing heart of a microcoded control unit. It keeps a micro-program counter that addresses an internal control-store ROM, and a microinstruction register that holds the word most recently read. On every clock edge the addressed word moves into that register and the counter takes a new value. The new value comes from one of four sources: the counter plus one, a start address found by looking up the current instruction's opcode, an externally supplied entry address, or the branch target carried inside the word itself.

Each stored word has three parts: a field of control strobes, a branch-control part, and a target address. The branch-control part has a 2-bit source select, an unconditional bit, four condition bits (on zero, on non-zero, on negative, on positive) and a routine-end marker. A non-increment source is used only when the word's unconditional bit is set or one of its enabled conditions holds. Otherwise the counter steps by one. A build-time mode reads the two condition pins either as Z/N flags or as a CON/n pair in which "zero" means CON is low. The fetch routine sits at addresses 300 to 302. Its last word dispatches through the opcode, which is bits 31..27 of the instruction. Every routine ends with a return to 300.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a clock edge, `microPc` loads `extEntry` and `ctrlWord` and `routineEnd` become 0.
- R2: Out of reset, each edge copies the control field and end marker of the word at the old `microPc` onto `ctrlWord` and `routineEnd`.
- R3: Source select 00 steps `microPc` by one, and from CS_DEPTH-1 it wraps to 0. The word at 511 (control 0x81) steps on and so shows the wrap.
- R4: The fetch words at 300 and 301 step in turn, and the word at 302 (control 0x09) always dispatches on select 01. Opcodes 1, 2, 3 and 4 start at 400, 410, 420 and 430.
- R5: An opcode with no routine dispatches to `extEntry`.
- R6: Select 10 with a true condition loads `extEntry`. The word at 416 does this on its zero test.
- R7: Select 11 with the unconditional bit loads the word's target whatever the condition pins are. The loop at 420/421 repeats while its positive test fails.
- R8: In flag mode (COND_MODE=0) the zero test is `condZ`=1, the non-zero test is `condZ`=0, the negative test is `condN`=1 and the positive test is `condN`=0. Enabled tests are ORed.
- R9: When no enabled test holds and the unconditional bit is clear, or the select is 00, `microPc` steps by one.
- R10: In CON/n mode (COND_MODE=1) the zero test is `condZ`=0 (CON equals 0), the negative test is `condN`=1 and the positive test is `condN`=0.
- R11: A word with the end marker set also branches back to 300, so `routineEnd`=1 is always seen together with `microPc`=300.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, selects the external entry |
| opcode | input | 5 | Opcode field of the current instruction |
| extEntry | input | ADDR_W | External entry address for reset and exceptions |
| condZ | input | 1 | Zero flag, or CON in CON/n mode |
| condN | input | 1 | Negative flag, or n in CON/n mode |
| microPc | output | ADDR_W | Micro-program counter |
| ctrlWord | output | CTRL_W | Control-signal field of the microinstruction register |
| routineEnd | output | 1 | End marker of the current microinstruction |

## Verification
The bench builds two copies with the default 9-bit address, 512-word store and 8-bit control field. One copy is in flag mode and one is in CON/n mode, and both get the same stimulus. Because the condition pins are shared, the two copies split onto different paths through the test routine on the same cycle, so both readings of the zero test can be seen at once. The 512-word depth places the wrap from 511 to 0 where a reset to `extEntry`=511 reaches it in a single step.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // Next-address source; the encoding is the select field stored in each word.
  typedef enum logic [1:0] {
    NS_INC = 2'b00,
    NS_OPC = 2'b01,
    NS_EXT = 2'b10,
    NS_BR  = 2'b11
  } nsel_e;

  // Branch-control part of a microword.
  typedef struct packed {
    nsel_e sel;
    logic  uncond;
    logic  brNz;
    logic  brZ;
    logic  brPos;
    logic  brNeg;
    logic  endMark;
  } brctl_t;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    nsel_e sel;
    logic  clearIr;
  } strobe_t;

  localparam int OPC_W   = 5;
  localparam int BRCTL_W = $bits(brctl_t);
endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int COND_MODE = 0
) (
  input  logic    rst,
  input  brctl_t  romBr,
  input  logic    condZ,
  input  logic    condN,
  output strobe_t stb
);
  logic zeroHit;
  logic negHit;
  logic taken;

  generate
    if (COND_MODE == 1) begin : g_conMode
      assign zeroHit = ~condZ;
    end else begin : g_flagMode
      assign zeroHit = condZ;
    end
  endgenerate

  assign negHit = condN;

  always_comb begin
    taken = romBr.uncond
          | (romBr.brNz  & ~zeroHit)
          | (romBr.brZ   &  zeroHit)
          | (romBr.brPos & ~negHit)
          | (romBr.brNeg &  negHit);
    stb.clearIr = rst;
    if (rst) begin
      stb.sel = NS_EXT;
    end else if (romBr.sel == NS_INC || !taken) begin
      stb.sel = NS_INC;
    end else begin
      stb.sel = romBr.sel;
    end
  end
endmodule

// File: rtl/useq_dpath.sv
module useq_dpath
  import useq_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int CS_DEPTH = 512,
  parameter int CTRL_W   = 8
) (
  input  logic              clk,
  input  strobe_t           stb,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [ADDR_W-1:0] extEntry,
  output brctl_t            romBr,
  output logic [ADDR_W-1:0] romBaddr,
  output logic [CTRL_W-1:0] romCtrl,
  output logic [ADDR_W-1:0] microPc,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              routineEnd
);
  localparam int WORD_W = CTRL_W + BRCTL_W + ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(CS_DEPTH - 1);

  logic [WORD_W-1:0] romData;
  logic [ADDR_W-1:0] incPc;
  logic [ADDR_W-1:0] opcTarget;
  logic              opcHit;
  logic [ADDR_W-1:0] nextPc;

  // bits = {uncond, brNz, brZ, brPos, brNeg}
  function automatic logic [WORD_W-1:0] mk(input logic [7:0] c, input nsel_e s,
                                           input logic [4:0] bits, input logic e,
                                           input int a);
    brctl_t b;
    b = '{sel: s, uncond: bits[4], brNz: bits[3], brZ: bits[2],
          brPos: bits[1], brNeg: bits[0], endMark: e};
    return {CTRL_W'(c), b, ADDR_W'(a)};
  endfunction

  // Control store, fixed at build time.
  always_comb begin
    case (int'(microPc))
      300: romData = mk(8'h03, NS_INC, 5'b00000, 1'b0, 0);
      301: romData = mk(8'h05, NS_INC, 5'b00000, 1'b0, 0);
      302: romData = mk(8'h09, NS_OPC, 5'b10000, 1'b0, 0);
      400: romData = mk(8'h10, NS_INC, 5'b00000, 1'b0, 0);
      401: romData = mk(8'h30, NS_INC, 5'b00000, 1'b0, 0);
      402: romData = mk(8'h41, NS_BR,  5'b10000, 1'b1, 300);
      410: romData = mk(8'h12, NS_BR,  5'b00100, 1'b0, 414);
      411: romData = mk(8'h14, NS_BR,  5'b00001, 1'b0, 417);
      412: romData = mk(8'h18, NS_BR,  5'b00010, 1'b0, 416);
      413: romData = mk(8'h1c, NS_BR,  5'b01000, 1'b0, 417);
      414: romData = mk(8'h42, NS_BR,  5'b10000, 1'b1, 300);
      416: romData = mk(8'h20, NS_EXT, 5'b00100, 1'b0, 0);
      417: romData = mk(8'h44, NS_BR,  5'b10000, 1'b1, 300);
      420: romData = mk(8'h21, NS_BR,  5'b00010, 1'b0, 422);
      421: romData = mk(8'h22, NS_BR,  5'b10000, 1'b0, 420);
      422: romData = mk(8'h48, NS_BR,  5'b10000, 1'b1, 300);
      430: romData = mk(8'h23, NS_BR,  5'b00101, 1'b0, 414);
      431: romData = mk(8'h24, NS_INC, 5'b00000, 1'b0, 0);
      432: romData = mk(8'h50, NS_BR,  5'b10000, 1'b1, 300);
      500: romData = mk(8'h80, NS_BR,  5'b10000, 1'b1, 300);
      511: romData = mk(8'h81, NS_INC, 5'b00000, 1'b0, 0);
      default: romData = '0;
    endcase
  end

  assign {romCtrl, romBr, romBaddr} = romData;

  // Opcode dispatch table.
  always_comb begin
    opcHit    = 1'b1;
    opcTarget = '0;
    case (opcode)
      5'd1:    opcTarget = ADDR_W'(400);
      5'd2:    opcTarget = ADDR_W'(410);
      5'd3:    opcTarget = ADDR_W'(420);
      5'd4:    opcTarget = ADDR_W'(430);
      default: opcHit = 1'b0;
    endcase
  end

  assign incPc = (microPc == LAST) ? '0 : microPc + 1'b1;

  always_comb begin
    case (stb.sel)
      NS_INC:  nextPc = incPc;
      NS_OPC:  nextPc = opcHit ? opcTarget : extEntry;
      NS_EXT:  nextPc = extEntry;
      default: nextPc = romBaddr;
    endcase
  end

  always_ff @(posedge clk) begin
    microPc <= nextPc;
    if (stb.clearIr) begin
      ctrlWord   <= '0;
      routineEnd <= 1'b0;
    end else begin
      ctrlWord   <= romCtrl;
      routineEnd <= romBr.endMark;
    end
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int CS_DEPTH  = 512,
  parameter int CTRL_W    = 8,
  parameter int COND_MODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        opcode,
  input  logic [ADDR_W-1:0] extEntry,
  input  logic              condZ,
  input  logic              condN,
  output logic [ADDR_W-1:0] microPc,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              routineEnd
);
  strobe_t           stb;
  brctl_t            romBr;
  logic [ADDR_W-1:0] romBaddr;
  logic [CTRL_W-1:0] romCtrl;

  useq_ctrl #(.COND_MODE(COND_MODE)) u_ctrl (
    .rst   (rst),
    .romBr (romBr),
    .condZ (condZ),
    .condN (condN),
    .stb   (stb)
  );

  useq_dpath #(.ADDR_W(ADDR_W), .CS_DEPTH(CS_DEPTH), .CTRL_W(CTRL_W)) u_dpath (
    .clk        (clk),
    .stb        (stb),
    .opcode     (opcode),
    .extEntry   (extEntry),
    .romBr      (romBr),
    .romBaddr   (romBaddr),
    .romCtrl    (romCtrl),
    .microPc    (microPc),
    .ctrlWord   (ctrlWord),
    .routineEnd (routineEnd)
  );
endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int CS_DEPTH = 512,
  parameter int CTRL_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] extEntry,
  input logic [ADDR_W-1:0] microPc,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic              routineEnd,
  input strobe_t           stb,
  input brctl_t            romBr,
  input logic [ADDR_W-1:0] romBaddr,
  input logic [CTRL_W-1:0] romCtrl
);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(CS_DEPTH - 1);
  localparam logic [ADDR_W-1:0] FETCH = ADDR_W'(300);

  assert_reset_entry_R1: assert property (@(posedge clk)
    rst |=> (microPc == $past(extEntry) && ctrlWord == '0 && !routineEnd));

  assert_ir_copy_R2: assert property (@(posedge clk) disable iff (rst)
    !stb.clearIr |=> (ctrlWord == $past(romCtrl) && routineEnd == $past(romBr.endMark)));

  assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    stb.sel == NS_INC |=>
      microPc == (($past(microPc) == LAST) ? '0 : ADDR_W'($past(microPc) + 1'b1)));

  assert_ext_load_R6: assert property (@(posedge clk) disable iff (rst)
    stb.sel == NS_EXT |=> microPc == $past(extEntry));

  assert_branch_load_R7: assert property (@(posedge clk) disable iff (rst)
    stb.sel == NS_BR |=> microPc == $past(romBaddr));

  assert_fallthrough_R9: assert property (@(posedge clk) disable iff (rst)
    romBr.sel == NS_INC |-> stb.sel == NS_INC);

  assert_end_return_R11: assert property (@(posedge clk) disable iff (rst)
    routineEnd |-> microPc == FETCH);
endmodule

bind useq_top useq_checker #(.ADDR_W(ADDR_W), .CS_DEPTH(CS_DEPTH), .CTRL_W(CTRL_W)) chk (.*);

// File: tb/tb_useq_top.sv
module tb_useq_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int DEPTH = 512;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] opcode = 5'd0;
  logic [AW-1:0] extEntry = 9'd300;
  logic condZ = 1'b0;
  logic condN = 1'b0;

  wire [AW-1:0] pcA, pcB;
  wire [CW-1:0] ctlA, ctlB;
  wire endA, endB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string req = "R1";
  int mPc[2];
  int mCtl[2];
  int mEnd[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_top #(.ADDR_W(AW), .CS_DEPTH(DEPTH), .CTRL_W(CW), .COND_MODE(0)) dut (
    .clk(clk), .rst(rst), .opcode(opcode), .extEntry(extEntry), .condZ(condZ), .condN(condN),
    .microPc(pcA), .ctrlWord(ctlA), .routineEnd(endA));

  useq_top #(.ADDR_W(AW), .CS_DEPTH(DEPTH), .CTRL_W(CW), .COND_MODE(1)) dutCon (
    .clk(clk), .rst(rst), .opcode(opcode), .extEntry(extEntry), .condZ(condZ), .condN(condN),
    .microPc(pcB), .ctrlWord(ctlB), .routineEnd(endB));

  // Reference program as given by the requirements.
  task automatic refWord(input int a, output int ctl, output int sel, output int unc,
                         output int bnz, output int bz, output int bp, output int bn,
                         output int en, output int ba);
    ctl = 0; sel = 0; unc = 0; bnz = 0; bz = 0; bp = 0; bn = 0; en = 0; ba = 0;
    case (a)
      300: ctl = 'h03;
      301: ctl = 'h05;
      302: begin ctl = 'h09; sel = 1; unc = 1; end
      400: ctl = 'h10;
      401: ctl = 'h30;
      402: begin ctl = 'h41; sel = 3; unc = 1; en = 1; ba = 300; end
      410: begin ctl = 'h12; sel = 3; bz = 1; ba = 414; end
      411: begin ctl = 'h14; sel = 3; bn = 1; ba = 417; end
      412: begin ctl = 'h18; sel = 3; bp = 1; ba = 416; end
      413: begin ctl = 'h1c; sel = 3; bnz = 1; ba = 417; end
      414: begin ctl = 'h42; sel = 3; unc = 1; en = 1; ba = 300; end
      416: begin ctl = 'h20; sel = 2; bz = 1; end
      417: begin ctl = 'h44; sel = 3; unc = 1; en = 1; ba = 300; end
      420: begin ctl = 'h21; sel = 3; bp = 1; ba = 422; end
      421: begin ctl = 'h22; sel = 3; unc = 1; ba = 420; end
      422: begin ctl = 'h48; sel = 3; unc = 1; en = 1; ba = 300; end
      430: begin ctl = 'h23; sel = 3; bz = 1; bn = 1; ba = 414; end
      431: ctl = 'h24;
      432: begin ctl = 'h50; sel = 3; unc = 1; en = 1; ba = 300; end
      500: begin ctl = 'h80; sel = 3; unc = 1; en = 1; ba = 300; end
      511: ctl = 'h81;
      default: ;
    endcase
  endtask

  function automatic int opcMap(input int op, input int ext);
    case (op)
      1: return 400;
      2: return 410;
      3: return 420;
      4: return 430;
      default: return ext; // R5
    endcase
  endfunction

  task automatic modelStep(input int m);
    int ctl, sel, unc, bnz, bz, bp, bn, en, ba, nxt;
    bit zh, nh, take;
    if (rst) begin
      mPc[m] = int'(extEntry); mCtl[m] = 0; mEnd[m] = 0;
    end else begin
      refWord(mPc[m], ctl, sel, unc, bnz, bz, bp, bn, en, ba);
      mCtl[m] = ctl;
      mEnd[m] = en;
      zh = (m == 1) ? (condZ == 1'b0) : (condZ == 1'b1); // R8 / R10
      nh = (condN == 1'b1);
      take = (unc != 0) || (bnz != 0 && !zh) || (bz != 0 && zh) || (bp != 0 && !nh) || (bn != 0 && nh);
      nxt = (mPc[m] + 1) % DEPTH;
      if (sel != 0 && take) begin
        case (sel)
          1: nxt = opcMap(int'(opcode), int'(extEntry));
          2: nxt = int'(extEntry);
          default: nxt = ba;
        endcase
      end
      mPc[m] = nxt;
    end
  endtask

  task automatic checkEq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    modelStep(0);
    modelStep(1);
    @(negedge clk);
    checkEq(req, "flag microPc", int'(pcA), mPc[0]);
    checkEq(req, "flag ctrlWord", int'(ctlA), mCtl[0]);
    checkEq(req, "flag routineEnd", int'(endA), mEnd[0]);
    checkEq("R10", "con microPc", int'(pcB), mPc[1]);
    checkEq("R10", "con ctrlWord", int'(ctlB), mCtl[1]);
    checkEq("R10", "con routineEnd", int'(endB), mEnd[1]);
  endtask

  task automatic restart(input int ext);
    extEntry = AW'(ext);
    rst = 1'b1;
    cycle();
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    req = "R1";
    cycle(); cycle();
    checkEq("R1", "reset pc", int'(pcA), 300);
    checkEq("R1", "reset ctrl", int'(ctlA), 0);
    checkEq("R1", "reset end", int'(endA), 0);
    rst = 1'b0;

    // R4 fetch and dispatch, R2 register copy, R11 end/return
    req = "R4"; opcode = 5'd1;
    cycle(); cycle(); cycle();
    checkEq("R4", "dispatch op1", int'(pcA), 400);
    checkEq("R2", "ctrl of 302", int'(ctlA), 'h09);
    req = "R11";
    cycle(); cycle(); cycle();
    checkEq("R11", "end marker", int'(endA), 1);
    checkEq("R11", "return pc", int'(pcA), 300);
    checkEq("R2", "ctrl of 402", int'(ctlA), 'h41);

    // R10 zero test read as CON==0 in CON mode
    req = "R10"; opcode = 5'd2; condZ = 1'b0; condN = 1'b0;
    restart(300);
    cycle(); cycle(); cycle(); cycle();
    checkEq("R8", "flag mode Z=0 falls to 411", int'(pcA), 411);
    checkEq("R10", "con mode CON=0 branches 414", int'(pcB), 414);

    // R8 / R9 condition combinations on the test routine
    req = "R8";
    for (int zf = 0; zf < 2; zf++) begin
      for (int nf = 0; nf < 2; nf++) begin
        condZ = zf[0]; condN = nf[0];
        restart(300);
        for (int k = 0; k < 10; k++) cycle();
      end
    end
    req = "R9"; opcode = 5'd4;
    for (int zf = 0; zf < 2; zf++) begin
      condZ = zf[0]; condN = 1'b0;
      restart(300);
      for (int k = 0; k < 9; k++) cycle();
    end

    // R6 external source via word 416
    req = "R6"; opcode = 5'd2; condZ = 1'b0; condN = 1'b0;
    restart(300);
    for (int k = 0; k < 6; k++) cycle();
    condZ = 1'b1;
    cycle();
    checkEq("R6", "ext on zero", int'(pcA), 300);
    extEntry = 9'd500;
    condZ = 1'b0;
    restart(300);
    extEntry = 9'd500;
    for (int k = 0; k < 6; k++) cycle();
    condZ = 1'b1;
    cycle();
    checkEq("R6", "ext entry 500", int'(pcA), 500);
    cycle();
    checkEq("R7", "exception returns", int'(pcA), 300);

    // R5 unmapped opcode
    req = "R5"; opcode = 5'd7; condZ = 1'b0;
    restart(300);
    extEntry = 9'd500;
    cycle(); cycle(); cycle();
    checkEq("R5", "unmapped to ext", int'(pcA), 500);
    cycle();

    // R7 loop while N
    req = "R7"; opcode = 5'd3; condN = 1'b1;
    restart(300);
    cycle(); cycle(); cycle();
    checkEq("R7", "loop head", int'(pcA), 420);
    cycle(); cycle();
    checkEq("R7", "loop back", int'(pcA), 420);
    cycle(); cycle();
    condN = 1'b0;
    cycle();
    checkEq("R7", "loop exit", int'(pcA), 422);
    cycle();
    checkEq("R11", "loop routine end", int'(endA), 1);

    // R3 wrap from the last address
    req = "R3";
    restart(511);
    cycle();
    checkEq("R3", "wrap to 0", int'(pcA), 0);
    checkEq("R3", "ctrl of 511", int'(ctlA), 'h81);
    for (int k = 0; k < 5; k++) cycle();

    // Mixed traffic
    req = "R8";
    restart(300);
    for (int i = 0; i < 160; i++) begin
      opcode = 5'((i / 7) % 8);
      condZ = i[1] ^ i[4];
      condN = i[2];
      extEntry = i[5] ? 9'd500 : 9'd300;
      cycle();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule